// File: doc/BRIEF.md
# Per-Channel Gamma Lookup Table with Streaming Load Port

This block holds gamma correction tables for several display output channels and applies them to the pixels that flow through each channel. Every channel owns three tables, one for each of red, green and blue. Each table has 256 entries and each entry is 8 bits wide. All tables live in one packed address space. A host loads that space through two registers. The first is an address register that also carries an auto-increment flag. The second is a data register, and every write to it stores one entry.

On the pixel side, each channel presents a 24-bit RGB pixel with a valid flag. When gamma is enabled for that channel, every colour component is replaced by the matching table entry. When it is not enabled, the pixel passes through unchanged. In both cases the result appears one clock later, together with its valid flag.

When no channel has gamma enabled, the table storage is treated as powered down. Its content falls back to the identity mapping, and the host must load the tables again afterwards.

Top module: `gamma_lut`

## Requirements
- R1: The table address space places each channel after the previous one, in channel order. Within a channel, 256 red entries come first, then 256 green entries, then 256 blue entries. An address therefore maps to ch*768 + colour*256 + index, with colour 0 = red, 1 = green and 2 = blue. A data write stores `hostWdata[7:0]`.
- R2: A host write with `hostSel`=0 loads the address from `hostWdata[11:0]`. In the same write, `hostWdata[31]` sets the auto-increment flag.
- R3: A host write with `hostSel`=1 stores one entry at the current address. With the auto-increment flag set, the address then advances by one. Without the flag, the address stays put, so repeated writes land on the same entry.
- R4: `pixValidOut[c]` equals `pixValidIn[c]` from one cycle earlier. `pixOut` carries the result computed from the `pixIn` of that earlier cycle. Both outputs are zero while `rstN` is low.
- R5: For channel c, the pixel occupies `pixIn[24c+23:24c]`, with red in bits 23:16, green in 15:8 and blue in 7:0 of that slice. When `gammaEn[c]` is 1, each component is replaced by the entry it indexes in that channel's table for that colour.
- R6: When `gammaEn[c]` is 0, channel c's pixel is passed through unchanged. This holds even while other channels have gamma enabled and their tables are loaded.
- R7: After reset, every table holds the identity mapping (entry i = i).
- R8: While every bit of `gammaEn` is 0, data writes are discarded and all tables revert to the identity mapping. Tables loaded before that point are lost.
- R9: When a data write and a pixel lookup reach the same entry in the same cycle, the lookup returns the entry's previous value. The new value is seen from the next lookup on.
- R10: Data writes to addresses at or beyond 2304 change no table entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| hostWrEn | input | 1 | Host write strobe |
| hostSel | input | 1 | 0 = address register, 1 = data register |
| hostWdata | input | 32 | Host write data |
| gammaEn | input | 3 | Per-channel gamma enable |
| pixValidIn | input | 3 | Per-channel input pixel valid |
| pixIn | input | 72 | Input pixels, 24 bits per channel |
| pixValidOut | output | 3 | Per-channel output pixel valid |
| pixOut | output | 72 | Corrected or passed-through pixels |

## Verification
A host data write and a pixel lookup can land on the same table entry in the same clock cycle. The bench provokes this by pointing the address at channel 0's red entry 5 without auto-increment. In a single cycle it then drives a data write together with a channel 0 pixel whose red component is 5. The output of that lookup must show the entry's old value, and a second lookup one cycle later must show the new one. The same pairing is repeated with gamma disabled everywhere, where the write must leave no trace once gamma is enabled again.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
  // Write strobe handed from the host control to the table datapath.
  typedef struct packed {
    logic        wr;
    logic [3:0]  ch;
    logic [1:0]  comp;
    logic [15:0] idx;
    logic [15:0] data;
  } lutStrobe_t;
endpackage

// File: rtl/gamma_lut_ctrl.sv
module gamma_lut_ctrl
  import gamma_lut_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int ENTRIES = 256,
  parameter int DW      = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic        hostSel,
  input  logic [31:0] hostWdata,
  output lutStrobe_t  strobe
);
  localparam int CH_SPAN = 3 * ENTRIES;
  localparam int TOTAL   = NUM_CH * CH_SPAN;
  localparam int ADDR_W  = $clog2(TOTAL);

  logic [ADDR_W-1:0] addrReg;
  logic              autoInc;
  logic [ADDR_W-1:0] remWithinCh;
  logic              armed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      autoInc <= 1'b0;
      armed   <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (hostWrEn && !hostSel) begin
        addrReg <= ADDR_W'(hostWdata);
        autoInc <= hostWdata[31];
      end else if (hostWrEn && hostSel && autoInc) begin
        addrReg <= addrReg + 1'b1;
      end
    end
  end

  // Split the flat address into channel, colour and entry index.
  always_comb begin
    remWithinCh = addrReg % ADDR_W'(CH_SPAN);
    strobe.wr   = hostWrEn && hostSel && (32'(addrReg) < 32'(TOTAL));
    strobe.ch   = 4'(addrReg / ADDR_W'(CH_SPAN));
    strobe.comp = 2'(remWithinCh / ADDR_W'(ENTRIES));
    strobe.idx  = 16'(remWithinCh % ADDR_W'(ENTRIES));
    strobe.data = 16'(DW'(hostWdata));
  end

  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(hostWrEn && !hostSel) |-> addrReg == $past(hostWdata[ADDR_W-1:0])); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(hostWrEn && hostSel && autoInc) |-> addrReg == $past(addrReg) + 1'b1); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(hostWrEn && hostSel && !autoInc) |-> $stable(addrReg)); // R3
endmodule

// File: rtl/gamma_lut_dp.sv
module gamma_lut_dp
  import gamma_lut_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int ENTRIES = 256,
  parameter int DW      = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  lutStrobe_t               strobe,
  input  logic [NUM_CH-1:0]        gammaEn,
  input  logic [NUM_CH-1:0]        pixValidIn,
  input  logic [NUM_CH*3*DW-1:0]   pixIn,
  output logic [NUM_CH-1:0]        pixValidOut,
  output logic [NUM_CH*3*DW-1:0]   pixOut
);
  localparam int PW    = 3 * DW;
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int BANKS = NUM_CH * 3;

  logic             powerDown;
  logic [BANKS-1:0] bankWe;
  logic             armed;

  assign powerDown = ~|gammaEn;

  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    always_ff @(posedge clk) begin
      if (!rstN) pixValidOut[c] <= 1'b0;
      else       pixValidOut[c] <= pixValidIn[c];
    end

    for (genvar k = 0; k < 3; k++) begin : gComp
      localparam int SH = c * PW + (2 - k) * DW;
      logic [DW-1:0] mem [ENTRIES];
      logic [DW-1:0] inComp;
      logic [DW-1:0] outComp;

      assign inComp = pixIn[SH +: DW];
      assign bankWe[c*3+k] = strobe.wr && !powerDown &&
                             (strobe.ch == 4'(c)) && (strobe.comp == 2'(k));

      // Table bank: identity after reset and while powered down.
      always_ff @(posedge clk) begin
        if (!rstN || powerDown) begin
          for (int i = 0; i < ENTRIES; i++) mem[i] <= DW'(i);
        end else if (bankWe[c*3+k]) begin
          mem[IDX_W'(strobe.idx)] <= DW'(strobe.data);
        end
      end

      // Registered lookup; a same-cycle write is seen only afterwards.
      always_ff @(posedge clk) begin
        if (!rstN)           outComp <= '0;
        else if (gammaEn[c]) outComp <= mem[IDX_W'(inComp)];
        else                 outComp <= inComp;
      end

      assign pixOut[SH +: DW] = outComp;
    end

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rstN)
      armed |-> pixValidOut[c] == $past(pixValidIn[c])); // R4
    AST_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
      armed && !$past(gammaEn[c]) |-> pixOut[c*PW +: PW] == $past(pixIn[c*PW +: PW])); // R6
  end

  AST_BANK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bankWe)); // R1
  AST_OFF_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (gammaEn == '0) |-> (bankWe == '0)); // R8
endmodule

// File: rtl/gamma_lut.sv
module gamma_lut
  import gamma_lut_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int ENTRIES = 256,
  parameter int DW      = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   hostWrEn,
  input  logic                   hostSel,
  input  logic [31:0]            hostWdata,
  input  logic [NUM_CH-1:0]      gammaEn,
  input  logic [NUM_CH-1:0]      pixValidIn,
  input  logic [NUM_CH*3*DW-1:0] pixIn,
  output logic [NUM_CH-1:0]      pixValidOut,
  output logic [NUM_CH*3*DW-1:0] pixOut
);
  lutStrobe_t strobe;

  gamma_lut_ctrl #(.NUM_CH(NUM_CH), .ENTRIES(ENTRIES), .DW(DW)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostWrEn  (hostWrEn),
    .hostSel   (hostSel),
    .hostWdata (hostWdata),
    .strobe    (strobe)
  );

  gamma_lut_dp #(.NUM_CH(NUM_CH), .ENTRIES(ENTRIES), .DW(DW)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .gammaEn     (gammaEn),
    .pixValidIn  (pixValidIn),
    .pixIn       (pixIn),
    .pixValidOut (pixValidOut),
    .pixOut      (pixOut)
  );
endmodule

// File: tb/gamma_lut_test.sv
module gamma_lut_test;
  localparam int NUM_CH  = 3;
  localparam int ENTRIES = 256;
  localparam int DW      = 8;
  localparam int PW      = 3 * DW;
  localparam int TOTAL   = NUM_CH * 3 * ENTRIES;

  logic                   clk = 1'b0;
  logic                   rstN;
  logic                   hostWrEn;
  logic                   hostSel;
  logic [31:0]            hostWdata;
  logic [NUM_CH-1:0]      gammaEn;
  logic [NUM_CH-1:0]      pixValidIn;
  logic [NUM_CH*PW-1:0]   pixIn;
  logic [NUM_CH-1:0]      pixValidOut;
  logic [NUM_CH*PW-1:0]   pixOut;

  int checks = 0;
  int errors = 0;
  int expTab [NUM_CH][3][ENTRIES];

  always #4 clk = ~clk;

  gamma_lut #(.NUM_CH(NUM_CH), .ENTRIES(ENTRIES), .DW(DW)) uut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostSel(hostSel),
    .hostWdata(hostWdata), .gammaEn(gammaEn), .pixValidIn(pixValidIn),
    .pixIn(pixIn), .pixValidOut(pixValidOut), .pixOut(pixOut)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic modelIdentity();
    for (int c = 0; c < NUM_CH; c++)
      for (int k = 0; k < 3; k++)
        for (int i = 0; i < ENTRIES; i++) expTab[c][k][i] = i;
  endtask

  task automatic setAddr(input int a, input bit inc);
    hostWrEn = 1'b1; hostSel = 1'b0;
    hostWdata = 32'(a) | (inc ? 32'h8000_0000 : 32'h0);
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic writeData(input int v);
    hostWrEn = 1'b1; hostSel = 1'b1; hostWdata = 32'(v);
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  function automatic int expComp(input int c, input int k, input int v);
    return gammaEn[c] ? expTab[c][k][v] : v;
  endfunction

  // Drive one pixel on channel c, check the registered result one cycle later.
  task automatic lookup(input int c, input int r, input int g, input int b, input string req);
    logic [PW-1:0] expPix;
    expPix = {8'(expComp(c, 0, r)), 8'(expComp(c, 1, g)), 8'(expComp(c, 2, b))};
    pixIn = '0;
    pixIn[c*PW +: PW] = {8'(r), 8'(g), 8'(b)};
    pixValidIn = NUM_CH'(1 << c);
    @(negedge clk);
    check(pixValidOut == NUM_CH'(1 << c) && pixOut[c*PW +: PW] == expPix, req,
          {pixValidOut, pixOut[c*PW +: PW]}, {NUM_CH'(1 << c), expPix});
    pixValidIn = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; hostWrEn = 1'b0; hostSel = 1'b0; hostWdata = '0;
    gammaEn = '0; pixValidIn = '1; pixIn = '1;
    repeat (3) @(negedge clk);
    // R4: outputs held at zero in reset
    check(pixValidOut == '0 && pixOut == '0, "R4 reset", {pixValidOut, pixOut}, 0);
    rstN = 1'b1; pixValidIn = '0; pixIn = '0;
    @(negedge clk);
    modelIdentity();

    // R7: identity tables after reset
    gammaEn = '1;
    for (int c = 0; c < NUM_CH; c++)
      for (int v = 0; v < ENTRIES; v++)
        lookup(c, v, 255 - v, v ^ 8'h5a, "R7 identity");

    // R1 R2 R3: stream every entry with auto-increment
    setAddr(0, 1'b1);
    for (int a = 0; a < TOTAL; a++) begin
      writeData((a * 37 + 11) & 255);
      expTab[a / 768][(a % 768) / 256][a % 256] = (a * 37 + 11) & 255;
    end
    // R5: full sweep through the loaded tables
    for (int c = 0; c < NUM_CH; c++)
      for (int v = 0; v < ENTRIES; v++)
        lookup(c, v, (v + 85) & 255, (v + 170) & 255, "R5 R1 table");

    // R6: only channel 1 enabled, others bypass
    gammaEn = 3'b010;
    for (int v = 0; v < ENTRIES; v++) begin
      lookup(0, v, v ^ 8'h33, 255 - v, "R6 bypass ch0");
      lookup(2, (v + 7) & 255, v, v ^ 8'hc3, "R6 bypass ch2");
      lookup(1, v, v, v, "R6 ch1 table");
    end
    gammaEn = '1;

    // R2 R3: no auto-increment, repeated writes hit one entry
    setAddr(10, 1'b0);
    writeData(8'h11);
    writeData(8'h22);
    expTab[0][0][10] = 8'h22;
    lookup(0, 10, 0, 0, "R3 hold entry 10");
    lookup(0, 11, 0, 0, "R3 hold entry 11");

    // R10: writes past the last entry are discarded
    setAddr(TOTAL - 2, 1'b1);
    writeData(8'hab);
    writeData(8'hcd);
    writeData(8'hef);
    expTab[2][2][254] = 8'hab;
    expTab[2][2][255] = 8'hcd;
    lookup(2, 0, 0, 254, "R10 last-1");
    lookup(2, 0, 0, 255, "R10 last");
    lookup(0, 0, 0, 0, "R10 first untouched");
    setAddr(4095, 1'b0);
    writeData(8'h77);
    for (int v = 0; v < ENTRIES; v += 17) lookup(0, v, v, v, "R10 out of range");

    // R9: write and lookup on the same entry in one cycle
    setAddr(5, 1'b0);
    hostWrEn = 1'b1; hostSel = 1'b1; hostWdata = 32'h99;
    pixIn = '0; pixIn[23:16] = 8'd5; pixValidIn = 3'b001;
    @(negedge clk);
    check(pixOut[23:16] == 8'(expTab[0][0][5]), "R9 old value", pixOut[23:16], expTab[0][0][5]);
    hostWrEn = 1'b0; pixValidIn = '0;
    expTab[0][0][5] = 8'h99;
    lookup(0, 5, 0, 0, "R9 new value");

    // R8: all channels off discards writes and restores identity
    gammaEn = '0;
    writeData(8'h44);
    @(negedge clk);
    gammaEn = '1;
    modelIdentity();
    lookup(0, 5, 0, 0, "R8 discarded write");
    for (int v = 0; v < ENTRIES; v += 5) lookup(1, v, 255 - v, v, "R8 identity");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule